// File: doc/BRIEF.md
# Task Segment Switch Validator

This block decides whether the state segment of an incoming task may be adopted during a task switch. A requester presents every field the decision needs on the ports: the segment's own selector and descriptor limit, the local-table selector with its descriptor type and present bit, and six segment selectors for the stack, code and four data registers, each with a 4-bit descriptor type and a privilege level. Alongside these come the descriptor table limit, the privilege level the new task will run at, and a flag that says the switch was caused by an event outside program control. No memory is read. All descriptors arrive already fetched.

A one-cycle `start` pulse takes a snapshot of all inputs and begins a walk through eight checks, one per clock. The checks run in a fixed sequence: descriptor limit, local table, stack, code, then the four data selectors. The walk stops at the first failing check. Its result is a one-cycle `done` pulse together with one of two outcomes. With `fault` set, `err_code` names the failing selector and carries the external-origin flag, and the fault belongs to the old task's context. With `commit` set, the new task is accepted, and any later error belongs to it.

The controller has five states. `S_IDLE` waits for `start`. `S_LIMIT` checks the descriptor limit. `S_LDT` checks the local table. `S_SEG` steps through the six segment selectors. `S_REPORT` raises `done` for one cycle. The transitions are: IDLE to LIMIT on start. LIMIT to LDT on pass, or to REPORT on fail. LDT to SEG on pass, or to REPORT on fail. SEG to SEG while checks pass and selectors remain. SEG to REPORT on a failure or after the last selector. REPORT always returns to IDLE.

Top module: `tsv_top`

## Requirements
- R1: After reset, `done`, `fault` and `commit` are 0 and `err_code` is 0.
- R2: A task segment descriptor limit below 103 is a fault whose error code is built from `tss_sel`. A limit of exactly 103 passes.
- R3: The local-table check faults, reporting `ldt_sel`, in three cases: the selector lies outside the table, `ldt_present` is 0, or `ldt_type` is not 4'h2. A selector lies outside the table when {sel[15:3],3'b111} > `table_limit`.
- R4: The stack selector (slot 0) faults when it lies outside the table, or its type is not a writable data segment, or its DPL differs from `new_cpl`, or its sel[1:0] differs from `new_cpl`. Type encoding: bit 3 set means code. In a data type, bit 1 set means writable.
- R5: The code selector (slot 1) faults when it lies outside the table or its type bit 3 is 0 (not code).
- R6: For a code type with bit 2 clear (non-conforming), a DPL not equal to `new_cpl` faults. With bit 2 set (conforming), only a DPL greater than `new_cpl` faults.
- R7: Data selectors (slots 2 to 5) fault when they lie outside the table or refer to a code type whose bit 1 (readable) is 0. Data types always count as readable.
- R8: The checks run in the order limit, local table, slots 0 to 5, one per clock. Only the first failure is reported. `done` rises c+1 clocks after the clock edge that samples `start`, where c is the index of the failing check (0 to 7), or 7 when all checks pass.
- R9: On a fault, `err_code` = {sel[15:3], 2'b00, ext_evt}, with `ext_evt` as sampled at start.
- R10: When every check passes, `commit` is 1, `fault` is 0 and `err_code` is 0. `commit` and `fault` are never high together.
- R11: Inputs are captured at `start`. A `start` pulse and any input change while a check walk is in progress have no effect on its result.
- R12: `done`, `fault` and `commit` are single-cycle pulses. `err_code` is 0 whenever `fault` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin validation and capture all fields |
| ext_evt | input | 1 | Switch caused by an external event |
| new_cpl | input | 2 | Privilege level of the new task |
| table_limit | input | 16 | Descriptor table limit in bytes |
| tss_sel | input | 16 | Selector of the new task segment |
| tss_limit | input | 32 | Descriptor limit of the new task segment |
| ldt_sel | input | 16 | Local-table selector |
| ldt_type | input | 4 | Local-table descriptor type |
| ldt_present | input | 1 | Local-table descriptor present |
| seg_sel | input | 6x16 | Selectors: 0 stack, 1 code, 2..5 data |
| seg_type | input | 6x4 | Descriptor types per slot |
| seg_dpl | input | 6x2 | Descriptor privilege levels per slot |
| done | output | 1 | Result pulse |
| fault | output | 1 | Validation failed (with done) |
| commit | output | 1 | Switch accepted (with done) |
| err_code | output | 16 | Error code on fault, else 0 |

## Verification
Directed cases place a single defect at each check position, so the latency and the reported selector show which rule fired. Boundary values cover a limit of 102 against 103, a selector whose last byte lands exactly on the table limit against one entry beyond it, and conforming code at a lower, equal and higher DPL. Cases with several defects confirm that the earliest one in the order wins. A restart issued mid-walk, with the inputs changed at the same time, confirms that the captured snapshot alone decides the result. Random runs from a fixed seed mix mostly-valid fields with sparse corruptions and both values of the external flag, and the bench compares each run against its own reference function.

// File: rtl/tsv_pkg.sv
package tsv_pkg;
    localparam int SEL_W  = 16;
    localparam int NSEG   = 6;
    localparam int IDX_W  = $clog2(NSEG);
    localparam int SEG_SS = 0;
    localparam int SEG_CS = 1;

    // descriptor type bit positions
    localparam int T_CODE = 3;
    localparam int T_CONF = 2;
    localparam int T_RW   = 1;
    localparam logic [3:0] LDT_TYPE = 4'h2;

    typedef enum logic [2:0] {
        S_IDLE,
        S_LIMIT,
        S_LDT,
        S_SEG,
        S_REPORT
    } tsv_state_t;

    function automatic logic sel_beyond(input logic [SEL_W-1:0] sel,
                                        input logic [SEL_W-1:0] lim);
        return {sel[SEL_W-1:3], 3'b111} > lim;
    endfunction
endpackage

// File: rtl/tsv_check_unit.sv
module tsv_check_unit
    import tsv_pkg::*;
#(
    parameter int LIM_W     = 32,
    parameter int MIN_LIMIT = 103
) (
    input  tsv_state_t                    state,
    input  logic [IDX_W-1:0]              seg_idx,
    input  logic [1:0]                    cpl,
    input  logic [SEL_W-1:0]              table_limit,
    input  logic [SEL_W-1:0]              tss_sel,
    input  logic [LIM_W-1:0]              tss_limit,
    input  logic [SEL_W-1:0]              ldt_sel,
    input  logic [3:0]                    ldt_type,
    input  logic                          ldt_present,
    input  logic [NSEG-1:0][SEL_W-1:0]    seg_sel,
    input  logic [NSEG-1:0][3:0]          seg_type,
    input  logic [NSEG-1:0][1:0]          seg_dpl,
    output logic                          fail,
    output logic [SEL_W-1:0]              fail_sel
);
    logic [NSEG-1:0] seg_fail;
    logic            limit_bad;
    logic            ldt_bad;

    assign limit_bad = tss_limit < LIM_W'(MIN_LIMIT);
    assign ldt_bad   = sel_beyond(ldt_sel, table_limit) | ~ldt_present
                     | (ldt_type != LDT_TYPE);

    for (genvar g = 0; g < NSEG; g++) begin : g_seg
        logic beyond;
        assign beyond = sel_beyond(seg_sel[g], table_limit);
        if (g == SEG_SS) begin : g_stack
            assign seg_fail[g] = beyond
                               | seg_type[g][T_CODE]
                               | ~seg_type[g][T_RW]
                               | (seg_dpl[g] != cpl)
                               | (seg_sel[g][1:0] != cpl);
        end else if (g == SEG_CS) begin : g_code
            logic priv_bad;
            assign priv_bad = seg_type[g][T_CONF] ? (seg_dpl[g] > cpl)
                                                  : (seg_dpl[g] != cpl);
            assign seg_fail[g] = beyond | ~seg_type[g][T_CODE] | priv_bad;
        end else begin : g_data
            assign seg_fail[g] = beyond
                               | (seg_type[g][T_CODE] & ~seg_type[g][T_RW]);
        end
    end

    always_comb begin
        fail     = 1'b0;
        fail_sel = '0;
        unique case (state)
            S_LIMIT: begin
                fail     = limit_bad;
                fail_sel = tss_sel;
            end
            S_LDT: begin
                fail     = ldt_bad;
                fail_sel = ldt_sel;
            end
            S_SEG: begin
                fail     = seg_fail[seg_idx];
                fail_sel = seg_sel[seg_idx];
            end
            default: begin
                fail     = 1'b0;
                fail_sel = '0;
            end
        endcase
    end
endmodule

// File: rtl/tsv_errcode.sv
module tsv_errcode
    import tsv_pkg::*;
(
    input  logic [SEL_W-1:0] sel,
    input  logic             ext,
    output logic [SEL_W-1:0] code
);
    assign code = {sel[SEL_W-1:3], 2'b00, ext};
endmodule

// File: rtl/tsv_top.sv
module tsv_top
    import tsv_pkg::*;
#(
    parameter int LIM_W     = 32,
    parameter int MIN_LIMIT = 103
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic                       ext_evt,
    input  logic [1:0]                 new_cpl,
    input  logic [SEL_W-1:0]           table_limit,
    input  logic [SEL_W-1:0]           tss_sel,
    input  logic [LIM_W-1:0]           tss_limit,
    input  logic [SEL_W-1:0]           ldt_sel,
    input  logic [3:0]                 ldt_type,
    input  logic                       ldt_present,
    input  logic [NSEG-1:0][SEL_W-1:0] seg_sel,
    input  logic [NSEG-1:0][3:0]       seg_type,
    input  logic [NSEG-1:0][1:0]       seg_dpl,
    output logic                       done,
    output logic                       fault,
    output logic                       commit,
    output logic [SEL_W-1:0]           err_code
);
    localparam int NCHK  = NSEG + 2;
    localparam int CNT_W = $clog2(NCHK + 2);
    localparam logic [IDX_W-1:0] LAST_SEG = IDX_W'(NSEG - 1);

    tsv_state_t state_q, state_d;

    // snapshot captured at start
    logic                       ext_q;
    logic [1:0]                 cpl_q;
    logic [SEL_W-1:0]           tlim_q;
    logic [SEL_W-1:0]           tss_sel_q;
    logic [LIM_W-1:0]           tss_lim_q;
    logic [SEL_W-1:0]           ldt_sel_q;
    logic [3:0]                 ldt_type_q;
    logic                       ldt_pres_q;
    logic [NSEG-1:0][SEL_W-1:0] seg_sel_q;
    logic [NSEG-1:0][3:0]       seg_type_q;
    logic [NSEG-1:0][1:0]       seg_dpl_q;

    logic [IDX_W-1:0] seg_idx_q;
    logic             fail_q;
    logic [SEL_W-1:0] code_q;

    logic             chk_fail;
    logic [SEL_W-1:0] chk_sel;
    logic [SEL_W-1:0] chk_code;

    tsv_check_unit #(
        .LIM_W     (LIM_W),
        .MIN_LIMIT (MIN_LIMIT)
    ) u_check (
        .state       (state_q),
        .seg_idx     (seg_idx_q),
        .cpl         (cpl_q),
        .table_limit (tlim_q),
        .tss_sel     (tss_sel_q),
        .tss_limit   (tss_lim_q),
        .ldt_sel     (ldt_sel_q),
        .ldt_type    (ldt_type_q),
        .ldt_present (ldt_pres_q),
        .seg_sel     (seg_sel_q),
        .seg_type    (seg_type_q),
        .seg_dpl     (seg_dpl_q),
        .fail        (chk_fail),
        .fail_sel    (chk_sel)
    );

    tsv_errcode u_code (
        .sel  (chk_sel),
        .ext  (ext_q),
        .code (chk_code)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (start) state_d = S_LIMIT;
            S_LIMIT:  state_d = chk_fail ? S_REPORT : S_LDT;
            S_LDT:    state_d = chk_fail ? S_REPORT : S_SEG;
            S_SEG:    if (chk_fail || seg_idx_q == LAST_SEG) state_d = S_REPORT;
            S_REPORT: state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // capture and progress registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ext_q      <= 1'b0;
            cpl_q      <= '0;
            tlim_q     <= '0;
            tss_sel_q  <= '0;
            tss_lim_q  <= '0;
            ldt_sel_q  <= '0;
            ldt_type_q <= '0;
            ldt_pres_q <= 1'b0;
            seg_sel_q  <= '0;
            seg_type_q <= '0;
            seg_dpl_q  <= '0;
            seg_idx_q  <= '0;
            fail_q     <= 1'b0;
            code_q     <= '0;
        end else if (state_q == S_IDLE) begin
            if (start) begin
                ext_q      <= ext_evt;
                cpl_q      <= new_cpl;
                tlim_q     <= table_limit;
                tss_sel_q  <= tss_sel;
                tss_lim_q  <= tss_limit;
                ldt_sel_q  <= ldt_sel;
                ldt_type_q <= ldt_type;
                ldt_pres_q <= ldt_present;
                seg_sel_q  <= seg_sel;
                seg_type_q <= seg_type;
                seg_dpl_q  <= seg_dpl;
                seg_idx_q  <= '0;
                fail_q     <= 1'b0;
                code_q     <= '0;
            end
        end else if (state_q != S_REPORT) begin
            if (chk_fail) begin
                fail_q <= 1'b1;
                code_q <= chk_code;
            end else if (state_q == S_SEG) begin
                seg_idx_q <= seg_idx_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        done     = 1'b0;
        fault    = 1'b0;
        commit   = 1'b0;
        err_code = '0;
        unique case (state_q)
            S_REPORT: begin
                done     = 1'b1;
                fault    = fail_q;
                commit   = ~fail_q;
                err_code = fail_q ? code_q : '0;
            end
            default: begin
                done     = 1'b0;
                fault    = 1'b0;
                commit   = 1'b0;
                err_code = '0;
            end
        endcase
    end

    // cycles spent in check states, for the bounded-walk assertion
    logic [CNT_W-1:0] walk_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                        walk_cnt <= '0;
        else if (state_q == S_IDLE || state_q == S_REPORT) walk_cnt <= '0;
        else                                               walk_cnt <= walk_cnt + 1'b1;
    end

    AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && start) |=> (state_q == S_LIMIT)); // R8
    AST_WALK_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        walk_cnt <= CNT_W'(NCHK)); // R8
    AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_LDT || state_q == S_SEG) |=> (state_q != S_LIMIT)); // R11
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R12
    AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(fault && commit)); // R10
    AST_COMMIT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (err_code == '0)); // R10
    AST_CODE_FORMAT: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (err_code[2:1] == 2'b00)); // R9
    AST_QUIET_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        !fault |-> (err_code == '0)); // R12
endmodule

// File: tb/tsv_top_tb.sv
`timescale 1ns/1ps
module tsv_top_tb;
    import tsv_pkg::*;

    logic                       clk = 1'b0;
    logic                       rst_n = 1'b0;
    logic                       start = 1'b0;
    logic                       ext_evt = 1'b0;
    logic [1:0]                 new_cpl = '0;
    logic [15:0]                table_limit = '0;
    logic [15:0]                tss_sel = '0;
    logic [31:0]                tss_limit = '0;
    logic [15:0]                ldt_sel = '0;
    logic [3:0]                 ldt_type = '0;
    logic                       ldt_present = 1'b0;
    logic [NSEG-1:0][15:0]      seg_sel = '0;
    logic [NSEG-1:0][3:0]       seg_type = '0;
    logic [NSEG-1:0][1:0]       seg_dpl = '0;
    logic                       done, fault, commit;
    logic [15:0]                err_code;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    tsv_top u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .ext_evt(ext_evt),
        .new_cpl(new_cpl), .table_limit(table_limit), .tss_sel(tss_sel),
        .tss_limit(tss_limit), .ldt_sel(ldt_sel), .ldt_type(ldt_type),
        .ldt_present(ldt_present), .seg_sel(seg_sel), .seg_type(seg_type),
        .seg_dpl(seg_dpl), .done(done), .fault(fault), .commit(commit),
        .err_code(err_code)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit beyond(input logic [15:0] sel);
        return (int'(sel >> 3) * 8 + 7) > int'(table_limit);
    endfunction

    // reference: returns index of first failing check (8 = all pass)
    function automatic int model(output logic [15:0] code);
        logic [15:0] s;
        int c;
        bit bad;
        c = 8;
        s = '0;
        if (tss_limit < 32'd103) begin
            c = 0; s = tss_sel;
        end else if (beyond(ldt_sel) || !ldt_present || ldt_type != 4'h2) begin
            c = 1; s = ldt_sel;
        end else begin
            for (int i = 0; i < 6; i++) begin
                if (c == 8) begin
                    if (i == 0)
                        bad = beyond(seg_sel[0]) || seg_type[0][3] || !seg_type[0][1]
                              || seg_dpl[0] != new_cpl || seg_sel[0][1:0] != new_cpl;
                    else if (i == 1)
                        bad = beyond(seg_sel[1]) || !seg_type[1][3]
                              || (seg_type[1][2] ? (seg_dpl[1] > new_cpl)
                                                 : (seg_dpl[1] != new_cpl));
                    else
                        bad = beyond(seg_sel[i]) || (seg_type[i][3] && !seg_type[i][1]);
                    if (bad) begin
                        c = i + 2; s = seg_sel[i];
                    end
                end
            end
        end
        code = (c == 8) ? 16'h0 : {s[15:3], 2'b00, ext_evt};
        return c;
    endfunction

    // a fully valid baseline
    task automatic set_good();
        new_cpl     = 2'($urandom_range(0, 3));
        table_limit = 16'h00FF;
        tss_sel     = {11'($urandom_range(0, 31)), 5'b0};
        tss_limit   = 32'd103 + 32'($urandom_range(0, 500));
        ldt_sel     = {10'd0, 3'($urandom_range(0, 7)), 3'b000};
        ldt_type    = 4'h2;
        ldt_present = 1'b1;
        for (int i = 0; i < 6; i++) begin
            seg_sel[i] = {8'd0, 5'($urandom_range(0, 31)), 1'b0, new_cpl};
            seg_dpl[i] = new_cpl;
        end
        seg_type[0] = 4'b0010;
        seg_type[1] = 4'b1010;
        for (int i = 2; i < 6; i++)
            seg_type[i] = ($urandom_range(0, 1) == 1) ? 4'b1010 : 4'($urandom_range(0, 7));
    endtask

    // run one validation; the sampling of results follows R8 latency
    task automatic run(input string tag, input bit mid_restart);
        logic [15:0] ecode;
        int c, n, exp_lat;
        c = model(ecode);
        exp_lat = (c == 8) ? 8 : c + 1;
        @(negedge clk);
        start = 1'b1;
        @(posedge clk);
        #1 start = 1'b0;
        n = 0;
        while (!done && n < 20) begin
            if (mid_restart && n == 2) begin
                start = 1'b1; tss_limit = 32'd0; ldt_present = 1'b0;
                new_cpl = ~new_cpl; ext_evt = ~ext_evt;
            end else begin
                start = 1'b0;
            end
            @(posedge clk);
            #1 n++;
        end
        start = 1'b0;
        chk({tag, " R8 latency"}, 32'(n), 32'(exp_lat));
        chk({tag, " R10 commit"}, {31'd0, commit}, {31'd0, c == 8});
        chk({tag, " fault"}, {31'd0, fault}, {31'd0, c != 8});
        chk({tag, " R9 err_code"}, {16'd0, err_code}, {16'd0, ecode});
        @(posedge clk);
        #1;
        chk({tag, " R12 pulse"}, {29'd0, done, fault, commit}, 32'd0);
        chk({tag, " R12 code idle"}, {16'd0, err_code}, 32'd0);
    endtask

    initial begin
        void'($urandom(32'd1234));
        #7;
        chk("R1 reset done", {31'd0, done}, 32'd0);
        chk("R1 reset flags", {30'd0, fault, commit}, 32'd0);
        chk("R1 reset code", {16'd0, err_code}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        set_good(); run("R10 all pass", 0);
        set_good(); tss_limit = 32'd102; ext_evt = 1'b1; run("R2 limit 102", 0);
        set_good(); tss_limit = 32'd103; run("R2 limit 103", 0);
        set_good(); ext_evt = 1'b0; ldt_present = 1'b0; run("R3 not present", 0);
        set_good(); ldt_type = 4'h9; run("R3 bad type", 0);
        set_good(); ldt_sel = 16'h0100; run("R3 beyond table", 0);
        set_good(); ldt_sel = 16'h00F8; run("R3 last entry", 0);
        set_good(); seg_sel[0][1:0] = ~new_cpl; run("R4 rpl", 0);
        set_good(); seg_dpl[0] = ~new_cpl; run("R4 dpl", 0);
        set_good(); seg_type[0] = 4'b0000; run("R4 read-only", 0);
        set_good(); seg_type[0] = 4'b1010; run("R4 code as stack", 0);
        set_good(); seg_type[1] = 4'b0010; ext_evt = 1'b1; run("R5 not code", 0);
        set_good(); seg_sel[1] = 16'h0108; run("R5 beyond", 0);
        set_good(); new_cpl = 2'd2; seg_type[1] = 4'b1110; seg_dpl[1] = 2'd1;
            seg_sel[0][1:0] = 2'd2; seg_dpl[0] = 2'd2; run("R6 conf lower", 0);
        set_good(); new_cpl = 2'd1; seg_type[1] = 4'b1110; seg_dpl[1] = 2'd3;
            seg_sel[0][1:0] = 2'd1; seg_dpl[0] = 2'd1; run("R6 conf higher", 0);
        set_good(); seg_type[1] = 4'b1010; seg_dpl[1] = ~new_cpl; run("R6 nonconf ne", 0);
        set_good(); seg_sel[2] = 16'h0200; run("R7 DS beyond", 0);
        set_good(); seg_type[5] = 4'b1000; run("R7 GS unreadable", 0);
        set_good(); seg_type[4] = 4'b0000; run("R7 FS data ro ok", 0);
        set_good(); seg_type[3] = 4'b1000; seg_type[5] = 4'b1000; run("R8 first of two", 0);
        set_good(); ldt_present = 1'b0; seg_type[0] = 4'b0000; run("R8 early wins", 0);
        set_good(); run("R11 restart ignored", 1);
        set_good(); seg_type[2] = 4'b1000; run("R11 restart on fault", 1);

        for (int k = 0; k < 300; k++) begin
            set_good();
            ext_evt = 1'($urandom_range(0, 1));
            if ($urandom_range(0, 9) == 0) tss_limit = 32'($urandom_range(0, 200));
            if ($urandom_range(0, 9) == 0) ldt_present = 1'b0;
            if ($urandom_range(0, 9) == 0) ldt_type = 4'($urandom_range(0, 15));
            if ($urandom_range(0, 9) == 0) table_limit = 16'($urandom_range(0, 300));
            for (int i = 0; i < 6; i++) begin
                if ($urandom_range(0, 11) == 0) seg_type[i] = 4'($urandom_range(0, 15));
                if ($urandom_range(0, 11) == 0) seg_dpl[i] = 2'($urandom_range(0, 3));
                if ($urandom_range(0, 15) == 0) seg_sel[i] = 16'($urandom_range(0, 16'h03FF));
            end
            run("R8 random", 0);
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #500000;
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule